// File: doc/BRIEF.md
# DMA Port Stall Timeout Monitor

This block sits beside a DMA controller and watches how long each of its access requests stays outstanding on four ports: a dual-access RAM port, a single-access RAM port, an external memory port and a peripheral port. While a request on a monitored port is pending and not yet acknowledged, a per-port counter advances once per clock. When it reaches that port's fixed limit, the port raises a one-cycle timeout pulse. The monitor does not try to tell why a request is stalled. A core that holds the port and an address that does not exist are treated the same way: the stall is counted.

A sticky status register records which ports have timed out. A single bus-error interrupt to the processor core stays high while any status bit is set, and software clears the bits by writing ones. The two RAM ports can each be switched on or off through their own enable bit. The peripheral port is always monitored. The external memory port is never monitored.

Each port runs a small state machine with three states. ST_IDLE means the counter is zero. ST_COUNT means a stall is being counted. ST_EXPIRED means the limit was reached and the counter is saturated. The transitions are:
- ST_IDLE to ST_COUNT on start (pending, not acknowledged, enabled); the count becomes 1.
- ST_COUNT to ST_COUNT on advance; the count increments.
- ST_COUNT to ST_EXPIRED on expire, when the count already equals the limit and the stall goes on.
- ST_COUNT or ST_EXPIRED to ST_IDLE on release (acknowledge, request withdrawn or enable removed); the count returns to zero.
- ST_EXPIRED to ST_EXPIRED on hold.

Top module: `dma_stall_watch`

## Requirements
- R1: Port index 0 (dual-access RAM), with tmo_enable[0]=1, raises tmo_pulse[0] in the cycle after the 255th consecutive clock edge that samples req_pending[0]=1 and req_ack[0]=0.
- R2: Port index 1 (single-access RAM), with tmo_enable[1]=1, raises tmo_pulse[1] after 255 such consecutive edges on its own inputs. Ports 0 and 1 count independently and can expire in the same cycle.
- R3: Port index 3 (peripheral) raises tmo_pulse[3] after 127 such consecutive edges, whatever the value of tmo_enable.
- R4: Port index 2 (external memory) never raises tmo_pulse[2] or sets tmo_status[2], however long its request stays pending.
- R5: While tmo_enable[b]=0 (b = 0 or 1), port b holds its count at zero and raises no pulse. When the bit is set again, counting starts from zero at the next edge.
- R6: An edge that samples req_ack=1 or req_pending=0 on a port returns its count to zero, so a later stall needs the full limit again.
- R7: Each timeout pulse is high for exactly one cycle, and it does not fire again while the same request stays pending.
- R8: tmo_status[b] becomes 1 at the edge after tmo_pulse[b] is high. bus_err_irq is 1 whenever any status bit is 1 and 0 when all are 0.
- R9: A write (stat_clr_wr=1) clears every status bit whose stat_clr_mask bit is 1 and leaves bits with a mask bit of 0 unchanged. A timeout arriving at the same edge as its clear wins, and the bit stays 1.
- R10: After reset, tmo_status is 0, bus_err_irq is 0 and all pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pending | input | 4 | Per-port request outstanding (0 dual RAM, 1 single RAM, 2 external, 3 peripheral) |
| req_ack | input | 4 | Per-port grant/completion strobe |
| tmo_enable | input | 2 | Timeout enables from the control register: bit 0 dual RAM, bit 1 single RAM |
| stat_clr_wr | input | 1 | Status write strobe |
| stat_clr_mask | input | 4 | Write-one-to-clear mask for tmo_status |
| tmo_pulse | output | 4 | One-cycle timeout event per port |
| tmo_status | output | 4 | Sticky per-port timeout record |
| bus_err_irq | output | 1 | Merged bus-error interrupt |

## Verification
A stall that begins at the edge after bench cycle c produces its pulse while the cycle counter reads c plus the port limit. The status bit and the interrupt follow one edge after that. The driver pushes each expected pulse, with its port and due cycle, into a queue as it starts the stall. The monitor samples the pulses on falling edges, matches each against the head of the queue, and flags any pulse that is early, late, extra or missing. Status and interrupt values are read on falling edges a known number of edges after the stimulus, including the edge where a clear meets a new timeout.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

    localparam int NUM_PORTS   = 4;
    localparam int PORT_DUAL   = 0;
    localparam int PORT_SINGLE = 1;
    localparam int PORT_EXT    = 2;
    localparam int PORT_PERIPH = 3;
    localparam int NUM_GATED   = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } stall_st_t;

endpackage

// File: rtl/dsw_port_fsm.sv
module dsw_port_fsm
    import dsw_pkg::*;
#(
    parameter int LIMIT = 255,
    parameter bit GATED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pending,
    input  logic ack,
    output logic timeout
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_W = CW'(LIMIT);

    stall_st_t     state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          go;

    // A stall is counted only while the request waits and the port is armed
    assign go = pending && !ack && (enable || !GATED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_nxt = '0;
                if (go) begin
                    state_nxt = ST_COUNT;
                    cnt_nxt   = CW'(1);
                end
            end
            ST_COUNT: begin
                if (!go) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end else if (cnt == LIM_W) begin
                    state_nxt = ST_EXPIRED;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_EXPIRED: begin
                if (!go) begin
                    state_nxt = ST_IDLE;
                    cnt_nxt   = '0;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    always_comb begin
        timeout = (state == ST_COUNT) && (cnt == LIM_W);
    end

endmodule

// File: rtl/dsw_status.sv
module dsw_status #(
    parameter int NP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] set_vec,
    input  logic          clr_wr,
    input  logic [NP-1:0] clr_vec,
    output logic [NP-1:0] status,
    output logic          irq
);

    logic [NP-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_vec : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            // a fresh timeout outranks a simultaneous clear
            status <= (status & ~clr_eff) | set_vec;
        end
    end

    assign irq = |status;

endmodule

// File: rtl/dma_stall_watch.sv
module dma_stall_watch
    import dsw_pkg::*;
#(
    parameter int LIMIT_DUAL   = 255,
    parameter int LIMIT_SINGLE = 255,
    parameter int LIMIT_PERIPH = 127
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] req_pending,
    input  logic [NUM_PORTS-1:0] req_ack,
    input  logic [NUM_GATED-1:0] tmo_enable,
    input  logic                 stat_clr_wr,
    input  logic [NUM_PORTS-1:0] stat_clr_mask,
    output logic [NUM_PORTS-1:0] tmo_pulse,
    output logic [NUM_PORTS-1:0] tmo_status,
    output logic                 bus_err_irq
);

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        localparam int LIM = (g == PORT_DUAL)   ? LIMIT_DUAL   :
                             (g == PORT_SINGLE) ? LIMIT_SINGLE :
                             (g == PORT_PERIPH) ? LIMIT_PERIPH : 1;
        localparam bit GATE = (g != PORT_PERIPH);
        logic port_en;

        if (g < NUM_GATED) begin : g_sw_en
            assign port_en = tmo_enable[g];
        end else begin : g_fixed_en
            // external port stays disarmed; peripheral port ignores it
            assign port_en = 1'b0;
        end

        dsw_port_fsm #(
            .LIMIT (LIM),
            .GATED (GATE)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (port_en),
            .pending (req_pending[g]),
            .ack     (req_ack[g]),
            .timeout (tmo_pulse[g])
        );
    end

    dsw_status #(
        .NP (NUM_PORTS)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (tmo_pulse),
        .clr_wr  (stat_clr_wr),
        .clr_vec (stat_clr_mask),
        .status  (tmo_status),
        .irq     (bus_err_irq)
    );

endmodule

// File: rtl/dsw_checker.sv
module dsw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] req_pending,
    input logic [3:0] req_ack,
    input logic [1:0] tmo_enable,
    input logic       stat_clr_wr,
    input logic [3:0] stat_clr_mask,
    input logic [3:0] tmo_pulse,
    input logic [3:0] tmo_status,
    input logic       bus_err_irq
);

    p_ext_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_pulse[2] && !tmo_status[2]);

    p_dual_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tmo_enable[0]) |-> !tmo_pulse[0]);

    p_single_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tmo_enable[1]) |-> !tmo_pulse[1]);

    p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmo_status) |-> bus_err_irq);

    for (genvar b = 0; b < 4; b++) begin : g_bit
        p_released_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(req_pending[b]) || $past(req_ack[b])) |-> !tmo_pulse[b]);

        p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            tmo_pulse[b] |=> !tmo_pulse[b]);

        p_set_after_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            tmo_pulse[b] |=> tmo_status[b]);

        p_rise_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tmo_status[b]) |-> $past(tmo_pulse[b]));

        p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (tmo_status[b] && !(stat_clr_wr && stat_clr_mask[b])) |=> tmo_status[b]);
    end

endmodule

bind dma_stall_watch dsw_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_pending   (req_pending),
    .req_ack       (req_ack),
    .tmo_enable    (tmo_enable),
    .stat_clr_wr   (stat_clr_wr),
    .stat_clr_mask (stat_clr_mask),
    .tmo_pulse     (tmo_pulse),
    .tmo_status    (tmo_status),
    .bus_err_irq   (bus_err_irq)
);

// File: tb/dma_stall_watch_test.sv
`timescale 1ns/1ps
module dma_stall_watch_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_pending = '0;
    logic [3:0] req_ack = '0;
    logic [1:0] tmo_enable = '0;
    logic       stat_clr_wr = 1'b0;
    logic [3:0] stat_clr_mask = '0;
    logic [3:0] tmo_pulse;
    logic [3:0] tmo_status;
    logic       bus_err_irq;

    typedef struct {
        int port;
        int due;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   ended = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    dma_stall_watch uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_pending   (req_pending),
        .req_ack       (req_ack),
        .tmo_enable    (tmo_enable),
        .stat_clr_wr   (stat_clr_wr),
        .stat_clr_mask (stat_clr_mask),
        .tmo_pulse     (tmo_pulse),
        .tmo_status    (tmo_status),
        .bus_err_irq   (bus_err_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pulse(input int port, input int due);
        exp_t e;
        e.port = port;
        e.due  = due;
        q.push_back(e);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Monitor: every pulse must match the head of the queue, port and cycle
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            for (int p = 0; p < 4; p++) begin
                if (tmo_pulse[p]) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R7 unexpected pulse", p, -1);
                    end else begin
                        check(q[0].port == p && q[0].due == cyc,
                              "R1/R2/R3/R6 pulse port*1000+cycle",
                              p * 1000 + cyc, q[0].port * 1000 + q[0].due);
                        void'(q.pop_front());
                    end
                end
            end
            if (q.size() > 0 && q[0].due < cyc) begin
                check(1'b0, "R1/R2/R3 missing pulse", 0, q[0].due);
                void'(q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10 reset state
        check(tmo_status == 4'b0, "R10 status", tmo_status, 0);
        check(bus_err_irq == 1'b0, "R10 irq", bus_err_irq, 0);
        check(tmo_pulse == 4'b0, "R10 pulse", tmo_pulse, 0);

        // R1 dual RAM stall, then R7 no refire while it stays pending
        tmo_enable = 2'b11;
        c0 = cyc;
        req_pending[0] = 1'b1;
        expect_pulse(0, c0 + 255);
        tick(400);
        check(tmo_status == 4'b0001, "R8 status after R1 timeout", tmo_status, 1);
        check(bus_err_irq == 1'b1, "R8 irq raised", bus_err_irq, 1);
        req_pending[0] = 1'b0;

        // R9 write with mask bit 0 clear leaves the bit; then clear it
        stat_clr_wr = 1'b1;
        stat_clr_mask = 4'b1110;
        tick(1);
        stat_clr_wr = 1'b0;
        tick(1);
        check(tmo_status == 4'b0001, "R9 zero mask bit ignored", tmo_status, 1);
        stat_clr_wr = 1'b1;
        stat_clr_mask = 4'b0001;
        tick(1);
        stat_clr_wr = 1'b0;
        tick(1);
        check(tmo_status == 4'b0, "R9 write-one clears", tmo_status, 0);
        check(bus_err_irq == 1'b0, "R8 irq drops", bus_err_irq, 0);

        // R6 ack mid-stall on single RAM restarts the count (R2)
        c0 = cyc;
        req_pending[1] = 1'b1;
        tick(100);
        req_ack[1] = 1'b1;
        tick(1);
        req_ack[1] = 1'b0;
        expect_pulse(1, cyc + 255);
        tick(300);
        check(tmo_status == 4'b0010, "R2 status single RAM", tmo_status, 2);
        req_pending[1] = 1'b0;
        stat_clr_wr = 1'b1;
        stat_clr_mask = 4'b1111;
        tick(1);
        stat_clr_wr = 1'b0;

        // R2 both RAM ports expire in the same cycle
        c0 = cyc;
        req_pending[1:0] = 2'b11;
        expect_pulse(0, c0 + 255);
        expect_pulse(1, c0 + 255);
        tick(260);
        check(tmo_status == 4'b0011, "R2 simultaneous status", tmo_status, 3);
        req_pending[1:0] = 2'b00;
        stat_clr_wr = 1'b1;
        stat_clr_mask = 4'b0011;
        tick(1);
        stat_clr_wr = 1'b0;

        // R4 external port never times out
        req_pending[2] = 1'b1;
        tick(600);
        check(tmo_status == 4'b0, "R4 external status", tmo_status, 0);
        check(bus_err_irq == 1'b0, "R4 irq quiet", bus_err_irq, 0);
        req_pending[2] = 1'b0;

        // R5 disabled dual RAM stays quiet, then counts from zero when armed
        tmo_enable = 2'b10;
        req_pending[0] = 1'b1;
        tick(400);
        check(tmo_status == 4'b0, "R5 disabled port quiet", tmo_status, 0);
        tmo_enable = 2'b11;
        expect_pulse(0, cyc + 255);
        tick(260);
        check(tmo_status == 4'b0001, "R5 re-enabled timeout", tmo_status, 1);
        req_pending[0] = 1'b0;
        stat_clr_wr = 1'b1;
        stat_clr_mask = 4'b0001;
        tick(1);
        stat_clr_wr = 1'b0;

        // R3 peripheral port with enables off; R9 set beats same-edge clear
        tmo_enable = 2'b00;
        c0 = cyc;
        req_pending[3] = 1'b1;
        expect_pulse(3, c0 + 127);
        tick(127);
        stat_clr_wr = 1'b1;
        stat_clr_mask = 4'b1000;
        tick(1);
        stat_clr_wr = 1'b0;
        check(tmo_status == 4'b1000, "R9 set wins over clear", tmo_status, 8);
        check(bus_err_irq == 1'b1, "R3 irq from peripheral", bus_err_irq, 1);
        req_pending[3] = 1'b0;
        stat_clr_wr = 1'b1;
        tick(1);
        stat_clr_wr = 1'b0;
        tick(1);
        check(tmo_status == 4'b0, "R9 peripheral cleared", tmo_status, 0);

        tick(5);
        check(q.size() == 0, "R1/R2/R3 all pulses seen", q.size(), 0);
        finish_run();
    end

endmodule